// File: doc/BRIEF.md
# Tag-Based Bus Memory Protection Unit

This unit sits in front of three memories of a processor tile: a local scratchpad, a shared data memory and a local flash bank. Every bus access brings an address, a direction and a 6-bit tag naming the master that issued it. In the same cycle the unit answers with either a grant, which lets the transfer through to the memory, or an error, which keeps it away. Scratchpad and shared data memory each have their own bank of address regions. Each region carries a 64-bit read-enable map and a 64-bit write-enable map, with one bit per master tag. The flash bank is checked against a single 64-bit read-enable map.

A configuration port holds the bounds, the maps and the protection switches. Only masters whose bit is set in a 64-bit configuration access map may write through it. The first denied access is latched into a sticky record, and later denials leave that record alone until software clears it.

Top module: `tag_mpu`

## Requirements
- R1: After reset all regions are disabled, both protection switches are off, and the flash read map and the configuration access map are all ones. With a switch off, every access to that memory is granted. Register 0 reads 0xFFFFFFFF and register 4 reads 0.
- R2: The target encoding is 0 for scratchpad, 1 for shared data memory, 2 for flash and 3 for none. A region matches when it is enabled and lower <= address < upper. Bounds are stored with 32-byte granularity: write bits 4:0 are dropped, and a bound reads back with those bits zero. In the lower-bound word, bit 0 is the region enable.
- R3: Each region's permission is split by direction: a read uses the read map and a write uses the write map. The low word of a map covers tags 0-31 (bit n is tag n). The high word covers tags 32-63 (bit n is tag n+32).
- R4: With a memory's switch on, an access is granted when at least one matching region enables the tag for the access direction. Otherwise it is denied, and that includes an address that matches no region.
- R5: The two memories have independent region banks. Configuration register index = 128 + 64*memory + 8*region + field. Field 0 is the lower bound with enable, 1 the upper bound, 2/3 the read map low/high, and 4/5 the write map low/high.
- R6: A flash read is granted only when the tag's bit is set in the flash read map (register 2 low, register 3 high). Every flash write is denied.
- R7: Grant and error are combinational in the cycle the access is presented, and at most one of them is high. Both are low when no access is valid. An access to target 3 always errors.
- R8: The first denied access sets viol_pending and records the address (register 6) and the status (register 5). The status fields are bit 0 pending, bit 1 write, bits 3:2 target and bits 9:4 tag. Later denials leave the record unchanged.
- R9: A permitted write to register 5 with bit 0 set clears the pending flag, and a write with bit 0 clear has no effect. If a denial arrives in the same cycle as the clear, the new denial is recorded.
- R10: A configuration write is accepted only when cfg_tag's bit is set in the access map (register 0 low, register 1 high). A refused write raises cfg_err in the same cycle and changes nothing. Reads are open to all. Register 4 bits 1:0 are the scratchpad and shared switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_target | input | 2 | Memory addressed (0 scratchpad, 1 shared, 2 flash, 3 none) |
| acc_addr | input | 32 | Byte address of the access |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_tag | input | 6 | Master tag |
| acc_grant | output | 1 | Access may proceed |
| acc_error | output | 1 | Access refused, bus error |
| cfg_valid | input | 1 | Configuration access present |
| cfg_write | input | 1 | 1 for configuration write |
| cfg_addr | input | 8 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_tag | input | 6 | Tag of the configuring master |
| cfg_rdata | output | 32 | Combinational read data of cfg_addr |
| cfg_err | output | 1 | Configuration write refused |
| viol_pending | output | 1 | Sticky violation record is valid |

## Verification
acc_grant, acc_error, cfg_err and cfg_rdata depend only on the current inputs and the registered state. They are therefore due in the same cycle the stimulus is applied. Configuration writes, the violation record and viol_pending change one cycle later, after the next rising edge. The bench drives inputs just after the falling edge and compares every output 2 ns later against its behavioural model. The model advances its own state only after the rising edge, using the inputs that were present at that edge. This keeps each result in the cycle in which it is due.

// File: rtl/tmpu_pkg.sv
`timescale 1ns/1ps
package tmpu_pkg;
    localparam int TAG_W   = 6;
    localparam int NTAGS   = 1 << TAG_W;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int CADDR_W = 8;
    localparam int NMEM    = 2;

    typedef enum logic [1:0] {
        TGT_SCRATCH = 2'd0,
        TGT_SHARED  = 2'd1,
        TGT_FLASH   = 2'd2,
        TGT_NONE    = 2'd3
    } tgt_e;

    localparam logic [CADDR_W-1:0] RA_CFG_LO = 8'd0;
    localparam logic [CADDR_W-1:0] RA_CFG_HI = 8'd1;
    localparam logic [CADDR_W-1:0] RA_FL_LO  = 8'd2;
    localparam logic [CADDR_W-1:0] RA_FL_HI  = 8'd3;
    localparam logic [CADDR_W-1:0] RA_CTRL   = 8'd4;
    localparam logic [CADDR_W-1:0] RA_STAT   = 8'd5;
    localparam logic [CADDR_W-1:0] RA_VADDR  = 8'd6;

    typedef struct packed {
        logic              valid;
        logic              write;
        tgt_e              tgt;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
    } viol_rec_t;
endpackage

// File: rtl/tmpu_bank.sv
`timescale 1ns/1ps
module tmpu_bank
    import tmpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ALIGN_BITS  = 5,
    localparam int BW = ADDR_W - ALIGN_BITS
) (
    input  logic [BW-1:0]                         blk,
    input  logic                                  write,
    input  logic [TAG_W-1:0]                      tag,
    input  logic [NUM_REGIONS-1:0]                reg_en,
    input  logic [NUM_REGIONS-1:0][BW-1:0]        reg_lo,
    input  logic [NUM_REGIONS-1:0][BW-1:0]        reg_hi,
    input  logic [NUM_REGIONS-1:0][NTAGS-1:0]     rd_perm,
    input  logic [NUM_REGIONS-1:0][NTAGS-1:0]     wr_perm,
    output logic                                  allow
);
    logic [NUM_REGIONS-1:0] in_range;
    logic [NUM_REGIONS-1:0] perm_bit;

    for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : g_region
        assign in_range[gi] = reg_en[gi] && (blk >= reg_lo[gi]) && (blk < reg_hi[gi]);
        assign perm_bit[gi] = write ? wr_perm[gi][tag] : rd_perm[gi][tag];
    end

    assign allow = |(in_range & perm_bit);
endmodule

// File: rtl/tmpu_regs.sv
`timescale 1ns/1ps
module tmpu_regs
    import tmpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ALIGN_BITS  = 5,
    localparam int BW   = ADDR_W - ALIGN_BITS,
    localparam int HALF = NTAGS / 2
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         cfg_valid,
    input  logic                                         cfg_write,
    input  logic [CADDR_W-1:0]                           cfg_addr,
    input  logic [DATA_W-1:0]                            cfg_wdata,
    input  logic [TAG_W-1:0]                             cfg_tag,
    input  viol_rec_t                                    rec,
    output logic [DATA_W-1:0]                            cfg_rdata,
    output logic                                         cfg_err,
    output logic                                         clr_o,
    output logic [NMEM-1:0]                              prot_o,
    output logic [NTAGS-1:0]                             fl_rd_o,
    output logic [NMEM-1:0][NUM_REGIONS-1:0]             en_o,
    output logic [NMEM-1:0][NUM_REGIONS-1:0][BW-1:0]     lo_o,
    output logic [NMEM-1:0][NUM_REGIONS-1:0][BW-1:0]     hi_o,
    output logic [NMEM-1:0][NUM_REGIONS-1:0][NTAGS-1:0]  rd_o,
    output logic [NMEM-1:0][NUM_REGIONS-1:0][NTAGS-1:0]  wr_o
);
    localparam logic [3:0] RI_LIM = 4'(NUM_REGIONS);

    typedef struct packed {
        logic [NTAGS-1:0]                            cfg_en;
        logic [NTAGS-1:0]                            fl_rd;
        logic [NMEM-1:0]                             prot;
        logic [NMEM-1:0][NUM_REGIONS-1:0]            en;
        logic [NMEM-1:0][NUM_REGIONS-1:0][BW-1:0]    lo;
        logic [NMEM-1:0][NUM_REGIONS-1:0][BW-1:0]    hi;
        logic [NMEM-1:0][NUM_REGIONS-1:0][NTAGS-1:0] rd;
        logic [NMEM-1:0][NUM_REGIONS-1:0][NTAGS-1:0] wr;
    } cfg_t;

    cfg_t s_d, s_q;

    logic       is_region;
    logic       mi;
    logic [2:0] ri;
    logic [2:0] fi;
    logic       ri_ok;
    logic       wr_req;
    logic       wr_ok;

    assign is_region = cfg_addr[7];
    assign mi        = cfg_addr[6];
    assign ri        = cfg_addr[5:3];
    assign fi        = cfg_addr[2:0];
    assign ri_ok     = ({1'b0, ri} < RI_LIM);
    assign wr_req    = cfg_valid && cfg_write;
    assign wr_ok     = wr_req && s_q.cfg_en[cfg_tag];
    assign cfg_err   = wr_req && !s_q.cfg_en[cfg_tag];
    assign clr_o     = wr_ok && !is_region && (cfg_addr == RA_STAT) && cfg_wdata[0];

    // read mux
    always_comb begin
        cfg_rdata = '0;
        if (is_region) begin
            if (ri_ok) begin
                case (fi)
                    3'd0: cfg_rdata = {s_q.lo[mi][ri], {(ALIGN_BITS-1){1'b0}}, s_q.en[mi][ri]};
                    3'd1: cfg_rdata = {s_q.hi[mi][ri], {ALIGN_BITS{1'b0}}};
                    3'd2: cfg_rdata = s_q.rd[mi][ri][HALF-1:0];
                    3'd3: cfg_rdata = s_q.rd[mi][ri][NTAGS-1:HALF];
                    3'd4: cfg_rdata = s_q.wr[mi][ri][HALF-1:0];
                    3'd5: cfg_rdata = s_q.wr[mi][ri][NTAGS-1:HALF];
                    default: cfg_rdata = '0;
                endcase
            end
        end else begin
            case (cfg_addr)
                RA_CFG_LO: cfg_rdata = s_q.cfg_en[HALF-1:0];
                RA_CFG_HI: cfg_rdata = s_q.cfg_en[NTAGS-1:HALF];
                RA_FL_LO:  cfg_rdata = s_q.fl_rd[HALF-1:0];
                RA_FL_HI:  cfg_rdata = s_q.fl_rd[NTAGS-1:HALF];
                RA_CTRL:   cfg_rdata = DATA_W'(s_q.prot);
                RA_STAT:   cfg_rdata = DATA_W'({rec.tag, rec.tgt, rec.write, rec.valid});
                RA_VADDR:  cfg_rdata = rec.addr;
                default:   cfg_rdata = '0;
            endcase
        end
    end

    // next-state
    always_comb begin
        s_d = s_q;
        if (wr_ok) begin
            if (is_region) begin
                if (ri_ok) begin
                    case (fi)
                        3'd0: begin
                            s_d.lo[mi][ri] = cfg_wdata[ADDR_W-1:ALIGN_BITS];
                            s_d.en[mi][ri] = cfg_wdata[0];
                        end
                        3'd1: s_d.hi[mi][ri] = cfg_wdata[ADDR_W-1:ALIGN_BITS];
                        3'd2: s_d.rd[mi][ri][HALF-1:0]     = cfg_wdata;
                        3'd3: s_d.rd[mi][ri][NTAGS-1:HALF] = cfg_wdata;
                        3'd4: s_d.wr[mi][ri][HALF-1:0]     = cfg_wdata;
                        3'd5: s_d.wr[mi][ri][NTAGS-1:HALF] = cfg_wdata;
                        default: ;
                    endcase
                end
            end else begin
                case (cfg_addr)
                    RA_CFG_LO: s_d.cfg_en[HALF-1:0]     = cfg_wdata;
                    RA_CFG_HI: s_d.cfg_en[NTAGS-1:HALF] = cfg_wdata;
                    RA_FL_LO:  s_d.fl_rd[HALF-1:0]      = cfg_wdata;
                    RA_FL_HI:  s_d.fl_rd[NTAGS-1:HALF]  = cfg_wdata;
                    RA_CTRL:   s_d.prot                 = cfg_wdata[NMEM-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.cfg_en <= '1;
            s_q.fl_rd  <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign prot_o  = s_q.prot;
    assign fl_rd_o = s_q.fl_rd;
    assign en_o    = s_q.en;
    assign lo_o    = s_q.lo;
    assign hi_o    = s_q.hi;
    assign rd_o    = s_q.rd;
    assign wr_o    = s_q.wr;

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_write && !s_q.cfg_en[cfg_tag] |=> $stable(s_q)); // R10
    AST_REFUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> cfg_valid && cfg_write); // R10
endmodule

// File: rtl/tmpu_viol.sv
`timescale 1ns/1ps
module tmpu_viol
    import tmpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              hit_write,
    input  tgt_e              hit_tgt,
    input  logic [TAG_W-1:0]  hit_tag,
    input  logic [ADDR_W-1:0] hit_addr,
    input  logic              clear,
    output viol_rec_t         rec
);
    viol_rec_t rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (hit && (!rec_q.valid || clear)) begin
            rec_d.valid = 1'b1;
            rec_d.write = hit_write;
            rec_d.tgt   = hit_tgt;
            rec_d.tag   = hit_tag;
            rec_d.addr  = hit_addr;
        end else if (clear) begin
            rec_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign rec = rec_q;

    AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rec_q.valid && !clear |=> $stable(rec_q)); // R8
    AST_REC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rec_q.valid && clear && !hit |=> !rec_q.valid); // R9
    AST_REC_RETAKE: assert property (@(posedge clk) disable iff (!rst_n)
        clear && hit |=> rec_q.valid && rec_q.addr == $past(hit_addr)); // R9
endmodule

// File: rtl/tag_mpu.sv
`timescale 1ns/1ps
module tag_mpu
    import tmpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ALIGN_BITS  = 5,
    localparam int BW = ADDR_W - ALIGN_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic [1:0]           acc_target,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic                 acc_write,
    input  logic [TAG_W-1:0]     acc_tag,
    output logic                 acc_grant,
    output logic                 acc_error,
    input  logic                 cfg_valid,
    input  logic                 cfg_write,
    input  logic [CADDR_W-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    input  logic [TAG_W-1:0]     cfg_tag,
    output logic [DATA_W-1:0]    cfg_rdata,
    output logic                 cfg_err,
    output logic                 viol_pending
);
    logic [NMEM-1:0]                             prot_w;
    logic [NTAGS-1:0]                            fl_rd_w;
    logic [NMEM-1:0][NUM_REGIONS-1:0]            en_w;
    logic [NMEM-1:0][NUM_REGIONS-1:0][BW-1:0]    lo_w;
    logic [NMEM-1:0][NUM_REGIONS-1:0][BW-1:0]    hi_w;
    logic [NMEM-1:0][NUM_REGIONS-1:0][NTAGS-1:0] rd_w;
    logic [NMEM-1:0][NUM_REGIONS-1:0][NTAGS-1:0] wr_w;
    logic [NMEM-1:0]                             bank_allow;
    logic                                        clr_w;
    logic                                        ok;
    viol_rec_t                                   rec_w;
    tgt_e                                        tgt;

    assign tgt = tgt_e'(acc_target);

    tmpu_regs #(
        .NUM_REGIONS (NUM_REGIONS),
        .ALIGN_BITS  (ALIGN_BITS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_write (cfg_write),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_tag   (cfg_tag),
        .rec       (rec_w),
        .cfg_rdata (cfg_rdata),
        .cfg_err   (cfg_err),
        .clr_o     (clr_w),
        .prot_o    (prot_w),
        .fl_rd_o   (fl_rd_w),
        .en_o      (en_w),
        .lo_o      (lo_w),
        .hi_o      (hi_w),
        .rd_o      (rd_w),
        .wr_o      (wr_w)
    );

    for (genvar gm = 0; gm < NMEM; gm++) begin : g_bank
        tmpu_bank #(
            .NUM_REGIONS (NUM_REGIONS),
            .ALIGN_BITS  (ALIGN_BITS)
        ) u_bank (
            .blk     (acc_addr[ADDR_W-1:ALIGN_BITS]),
            .write   (acc_write),
            .tag     (acc_tag),
            .reg_en  (en_w[gm]),
            .reg_lo  (lo_w[gm]),
            .reg_hi  (hi_w[gm]),
            .rd_perm (rd_w[gm]),
            .wr_perm (wr_w[gm]),
            .allow   (bank_allow[gm])
        );
    end

    always_comb begin
        case (tgt)
            TGT_SCRATCH: ok = !prot_w[0] || bank_allow[0];
            TGT_SHARED:  ok = !prot_w[1] || bank_allow[1];
            TGT_FLASH:   ok = !acc_write && fl_rd_w[acc_tag];
            default:     ok = 1'b0;
        endcase
    end

    assign acc_grant = acc_valid && ok;
    assign acc_error = acc_valid && !ok;

    tmpu_viol u_viol (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (acc_error),
        .hit_write (acc_write),
        .hit_tgt   (tgt),
        .hit_tag   (acc_tag),
        .hit_addr  (acc_addr),
        .clear     (clr_w),
        .rec       (rec_w)
    );

    assign viol_pending = rec_w.valid;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !acc_grant && !acc_error); // R7
    AST_NONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_target == 2'd3 |-> acc_error); // R7
    AST_FLASH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_target == 2'd2 && acc_write |-> acc_error); // R6
    AST_OPEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_target == 2'd0 && !prot_w[0] |-> acc_grant); // R1
    AST_ERR_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        acc_error |=> viol_pending); // R8
endmodule

// File: tb/tag_mpu_bench.sv
`timescale 1ns/1ps
module tag_mpu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_target = 2'd0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic [5:0]  acc_tag = '0;
    logic        acc_grant, acc_error;
    logic        cfg_valid = 1'b0;
    logic        cfg_write = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [5:0]  cfg_tag = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_err, viol_pending;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    tag_mpu u_tag_mpu (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_target(acc_target), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_tag(acc_tag),
        .acc_grant(acc_grant), .acc_error(acc_error),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_tag(cfg_tag),
        .cfg_rdata(cfg_rdata), .cfg_err(cfg_err), .viol_pending(viol_pending)
    );

    // behavioural reference state
    bit [63:0] m_cfg = '1;
    bit [63:0] m_fl = '1;
    bit [1:0]  m_prot = '0;
    bit        m_en [2][8];
    bit [31:0] m_lo [2][8];
    bit [31:0] m_hi [2][8];
    bit [63:0] m_rd [2][8];
    bit [63:0] m_wr [2][8];
    bit        m_vv = 0, m_vw = 0;
    bit [1:0]  m_vt = 0;
    bit [5:0]  m_vtag = 0;
    bit [31:0] m_va = 0;

    function automatic bit m_ok();
        int t = acc_target;
        if (t == 2) return !acc_write && m_fl[acc_tag];
        if (t == 3) return 1'b0;
        if (!m_prot[t]) return 1'b1;
        for (int r = 0; r < 8; r++) begin
            bit [63:0] p = acc_write ? m_wr[t][r] : m_rd[t][r];
            if (m_en[t][r] && acc_addr >= m_lo[t][r] && acc_addr < m_hi[t][r] && p[acc_tag])
                return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic bit [31:0] m_rdata(bit [7:0] a);
        if (a[7]) begin
            int m = a[6];
            int r = a[5:3];
            case (a[2:0])
                3'd0: return m_lo[m][r] | 32'(m_en[m][r]);
                3'd1: return m_hi[m][r];
                3'd2: return m_rd[m][r][31:0];
                3'd3: return m_rd[m][r][63:32];
                3'd4: return m_wr[m][r][31:0];
                3'd5: return m_wr[m][r][63:32];
                default: return 32'd0;
            endcase
        end
        case (a)
            8'd0: return m_cfg[31:0];
            8'd1: return m_cfg[63:32];
            8'd2: return m_fl[31:0];
            8'd3: return m_fl[63:32];
            8'd4: return 32'(m_prot);
            8'd5: return {22'd0, m_vtag, m_vt, m_vw, m_vv};
            8'd6: return m_va;
            default: return 32'd0;
        endcase
    endfunction

    task automatic m_update();
        bit ok  = m_ok();
        bit hit = acc_valid && !ok;
        bit wok = cfg_valid && cfg_write && m_cfg[cfg_tag];
        bit clr = wok && cfg_addr == 8'd5 && cfg_wdata[0];
        if (wok) begin
            if (cfg_addr[7]) begin
                int m = cfg_addr[6];
                int r = cfg_addr[5:3];
                case (cfg_addr[2:0])
                    3'd0: begin m_lo[m][r] = cfg_wdata & 32'hFFFF_FFE0; m_en[m][r] = cfg_wdata[0]; end
                    3'd1: m_hi[m][r] = cfg_wdata & 32'hFFFF_FFE0;
                    3'd2: m_rd[m][r][31:0]  = cfg_wdata;
                    3'd3: m_rd[m][r][63:32] = cfg_wdata;
                    3'd4: m_wr[m][r][31:0]  = cfg_wdata;
                    3'd5: m_wr[m][r][63:32] = cfg_wdata;
                    default: ;
                endcase
            end else begin
                case (cfg_addr)
                    8'd0: m_cfg[31:0]  = cfg_wdata;
                    8'd1: m_cfg[63:32] = cfg_wdata;
                    8'd2: m_fl[31:0]   = cfg_wdata;
                    8'd3: m_fl[63:32]  = cfg_wdata;
                    8'd4: m_prot       = cfg_wdata[1:0];
                    default: ;
                endcase
            end
        end
        if (hit && (!m_vv || clr)) begin
            m_vv = 1; m_vw = acc_write; m_vt = acc_target; m_vtag = acc_tag; m_va = acc_addr;
        end else if (clr) begin
            m_vv = 0;
        end
    endtask

    task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    // compare every output mid-cycle, then advance the model after the edge
    task automatic cycle(string r);
        bit ok;
        #2;
        ok = m_ok();
        chk(r, "acc_grant", 32'(acc_grant), 32'(acc_valid && ok));
        chk(r, "acc_error", 32'(acc_error), 32'(acc_valid && !ok));
        chk(r, "cfg_err", 32'(cfg_err), 32'(cfg_valid && cfg_write && !m_cfg[cfg_tag]));
        chk(r, "cfg_rdata", cfg_rdata, m_rdata(cfg_addr));
        chk(r, "viol_pending", 32'(viol_pending), 32'(m_vv));
        @(posedge clk);
        m_update();
        @(negedge clk);
    endtask

    task automatic acc(logic [1:0] t, logic [31:0] a, logic w, logic [5:0] g, string r);
        acc_valid = 1; acc_target = t; acc_addr = a; acc_write = w; acc_tag = g;
        cfg_valid = 0; cfg_write = 0;
        cycle(r);
    endtask

    task automatic cfgw(logic [7:0] a, logic [31:0] d, logic [5:0] g, string r);
        acc_valid = 0;
        cfg_valid = 1; cfg_write = 1; cfg_addr = a; cfg_wdata = d; cfg_tag = g;
        cycle(r);
    endtask

    task automatic cfgr(logic [7:0] a, string r);
        acc_valid = 0;
        cfg_valid = 1; cfg_write = 0; cfg_addr = a; cfg_wdata = '0;
        cycle(r);
    endtask

    function automatic logic [7:0] ra(int m, int r, int f);
        return 8'(128 + 64 * m + 8 * r + f);
    endfunction

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int m = 0; m < 2; m++)
            for (int r = 0; r < 8; r++) begin
                m_en[m][r] = 0; m_lo[m][r] = 0; m_hi[m][r] = 0; m_rd[m][r] = 0; m_wr[m][r] = 0;
            end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1 reset state and open memories
        cfgr(8'd0, "R1"); cfgr(8'd1, "R1"); cfgr(8'd2, "R1");
        cfgr(8'd4, "R1"); cfgr(8'd5, "R1"); cfgr(ra(0, 0, 0), "R1");
        acc(2'd0, 32'h40, 1'b0, 6'd7, "R1");
        acc(2'd1, 32'h0012_3456, 1'b1, 6'd63, "R1");
        acc(2'd2, 32'h8000, 1'b0, 6'd33, "R1");
        // R6 flash write refused, R8 first record
        acc(2'd2, 32'h8000, 1'b1, 6'd4, "R6");
        acc(2'd3, 32'h10, 1'b0, 6'd9, "R7");
        cfgr(8'd5, "R8"); cfgr(8'd6, "R8");
        // R9 clear with bit0 low has no effect, then real clear
        cfgw(8'd5, 32'h0, 6'd0, "R9"); cfgr(8'd5, "R9");
        cfgw(8'd5, 32'h1, 6'd0, "R9"); cfgr(8'd5, "R9");

        // R2 bound alignment readback
        cfgw(ra(0, 3, 0), 32'hABCD_EF1E, 6'd0, "R2"); cfgr(ra(0, 3, 0), "R2");
        cfgw(ra(0, 3, 1), 32'h0000_0FFF, 6'd0, "R2"); cfgr(ra(0, 3, 1), "R2");
        // scratch region 0
        cfgw(ra(0, 0, 0), 32'h0000_1001, 6'd0, "R2");
        cfgw(ra(0, 0, 1), 32'h0000_2000, 6'd0, "R2");
        cfgw(ra(0, 0, 2), 32'h0000_0008, 6'd0, "R3");
        cfgw(ra(0, 0, 3), 32'h0000_0100, 6'd0, "R3");
        cfgw(ra(0, 0, 4), 32'h0000_0008, 6'd0, "R3");
        // shared region 2
        cfgw(ra(1, 2, 0), 32'h0000_1001, 6'd0, "R5");
        cfgw(ra(1, 2, 1), 32'h0000_1100, 6'd0, "R5");
        cfgw(ra(1, 2, 2), 32'h0000_0020, 6'd0, "R5");
        cfgr(ra(1, 2, 2), "R5");
        cfgw(8'd4, 32'h3, 6'd0, "R4");

        acc(2'd0, 32'h1000, 1'b0, 6'd3, "R2");
        acc(2'd0, 32'h1FFF, 1'b0, 6'd3, "R2");
        acc(2'd0, 32'h2000, 1'b0, 6'd3, "R2");
        acc(2'd0, 32'h0FFF, 1'b0, 6'd3, "R4");
        acc(2'd0, 32'h1800, 1'b1, 6'd3, "R3");
        acc(2'd0, 32'h1800, 1'b0, 6'd40, "R3");
        acc(2'd0, 32'h1800, 1'b1, 6'd40, "R3");
        acc(2'd0, 32'h1800, 1'b0, 6'd5, "R3");
        acc(2'd1, 32'h1000, 1'b0, 6'd5, "R5");
        acc(2'd1, 32'h1000, 1'b0, 6'd3, "R5");
        acc(2'd1, 32'h1100, 1'b0, 6'd5, "R5");
        acc(2'd0, 32'h9000, 1'b0, 6'd0, "R4");

        // overlapping region 7
        cfgw(ra(0, 7, 0), 32'h0000_1801, 6'd0, "R4");
        cfgw(ra(0, 7, 1), 32'h0000_3000, 6'd0, "R4");
        cfgw(ra(0, 7, 5), 32'h0000_0100, 6'd0, "R4");
        acc(2'd0, 32'h1900, 1'b1, 6'd40, "R4");
        acc(2'd0, 32'h2800, 1'b1, 6'd40, "R4");
        acc(2'd0, 32'h2800, 1'b0, 6'd40, "R4");
        acc(2'd0, 32'h1900, 1'b0, 6'd40, "R4");

        // R6 flash read map
        cfgw(8'd2, 32'h0, 6'd0, "R6");
        acc(2'd2, 32'h100, 1'b0, 6'd3, "R6");
        acc(2'd2, 32'h100, 1'b0, 6'd40, "R6");
        cfgw(8'd3, 32'h0000_0100, 6'd0, "R6");
        acc(2'd2, 32'h100, 1'b0, 6'd41, "R6");
        acc(2'd2, 32'h100, 1'b0, 6'd40, "R6");

        // R10 configuration write protection
        cfgw(8'd0, 32'h1, 6'd0, "R10");
        cfgw(8'd4, 32'h0, 6'd2, "R10");
        cfgr(8'd4, "R10");
        acc(2'd0, 32'h50, 1'b0, 6'd9, "R10");
        cfgw(8'd4, 32'h0, 6'd33, "R10");
        acc(2'd0, 32'h50, 1'b0, 6'd9, "R10");
        cfgw(8'd1, 32'h0, 6'd0, "R10");
        cfgw(8'd0, 32'hFFFF_FFFF, 6'd40, "R10");
        cfgr(8'd0, "R10");
        cfgw(8'd4, 32'h3, 6'd0, "R10");

        // R2 disable region
        acc(2'd0, 32'h1000, 1'b0, 6'd3, "R2");
        cfgw(ra(0, 0, 0), 32'h0000_1000, 6'd0, "R2");
        acc(2'd0, 32'h1000, 1'b0, 6'd3, "R2");

        // R8 record held, R9 clear and new violation in the same cycle
        cfgr(8'd5, "R8"); cfgr(8'd6, "R8");
        acc_valid = 1; acc_target = 2'd3; acc_addr = 32'hDEAD_BEE0; acc_write = 1; acc_tag = 6'd22;
        cfg_valid = 1; cfg_write = 1; cfg_addr = 8'd5; cfg_wdata = 32'h1; cfg_tag = 6'd0;
        cycle("R9");
        cfgr(8'd5, "R9"); cfgr(8'd6, "R9");
        cfgw(8'd5, 32'h1, 6'd0, "R9");
        cfgr(8'd5, "R9");
        acc_valid = 0; cfg_valid = 0;
        cycle("R7");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule